// File: doc/BRIEF.md
# Serial Sampling ADC Host Sequencer

This block runs a complete conversion cycle on an external 12-bit sampling converter on behalf of a host. The converter has three connections that matter here: a convert-start strobe, a busy status line that stays high while a conversion runs, and a full-duplex 16-bit serial port. The serial port is framed by an active-low frame-select line. For each request the sequencer starts a conversion. It shifts a 16-bit control word out to the converter and captures the 16-bit word the converter returns. It waits for the conversion to finish and then hands the result to the host with a one-cycle done strobe.

Each request can use one of three orderings. In the post-conversion ordering the frame runs only after busy falls. In the overlapped ordering the frame runs while the conversion is still in progress, which gives the highest sample rate. In software-start mode no strobe is pulsed: the conversion is started by writing the control word over the serial port. In every ordering the sequencer keeps the converter's input settling window, so a new conversion never starts too soon after busy fell. A conversion that never completes is abandoned after a bounded wait. Every time limit is given in nanoseconds and converted to clock cycles from the clock period.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adc_convst is 0, adc_sync and adc_sclk are 1, done and timeout_err are 0, and ready is 1.
- R2: Each convert-start pulse is high for exactly ceil(PULSE_NS/CLK_NS) clock cycles.
- R3: A convert-start rising edge, or the start of a software-start frame, comes no sooner than ceil(ACQ_NS/CLK_NS) cycles after adc_busy falls.
- R4: A frame holds adc_sync low for exactly 16 rising edges of adc_sclk. Successive adc_sclk edges are SCLK_HALF cycles apart, and adc_sclk is 1 whenever adc_sync is 1.
- R5: adc_din carries ctrl_word most significant bit first. It changes only on falling adc_sclk edges and is stable across each rising edge.
- R6: adc_dout is sampled on each rising adc_sclk edge, most significant bit first. raw_word is the 16 captured bits, and result equals raw_word[11:0].
- R7: With xfer_during=1 and sw_convert=0, the frame starts after the strobe ends while adc_busy is still 1.
- R8: With xfer_during=0 and sw_convert=0, the frame starts only after adc_busy has fallen.
- R9: With sw_convert=1, no strobe is pulsed. The frame runs first, and the block then waits for adc_busy to rise and fall.
- R10: done is high for exactly one cycle, after both the frame and the conversion have ended. raw_word and result change only together with done.
- R11: If adc_busy has not completed its high period within ceil((CONV_MAX_NS+MARGIN_NS)/CLK_NS) cycles after the strobe or software frame ends, timeout_err pulses for one cycle. In that case done stays 0 and ready returns to 1.
- R12: start_req is sampled only while ready is 1. A request made while an operation runs starts no extra conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Begin an operation (accepted while ready) |
| ctrl_word | input | FRAME_BITS (16) | Word shifted out to the converter |
| xfer_during | input | 1 | 1: frame overlaps the conversion; 0: frame after busy falls |
| sw_convert | input | 1 | 1: start conversion via the serial write instead of the strobe |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion strobe |
| timeout_err | output | 1 | One-cycle strobe: conversion did not complete in time |
| raw_word | output | FRAME_BITS (16) | Full word captured from the converter |
| result | output | RESULT_BITS (12) | Low bits of the captured word |
| adc_convst | output | 1 | Convert-start strobe, active high |
| adc_busy | input | 1 | Converter busy status (asynchronous) |
| adc_sync | output | 1 | Frame select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial data to the converter |
| adc_dout | input | 1 | Serial data from the converter |

## Verification
The bench keeps the default nanosecond limits with a 20 ns clock. This gives a 5-cycle strobe, a 20-cycle settling window and a 250-cycle conversion limit. It shortens SCLK_HALF to 2, so a frame takes 66 cycles and fits well inside a modelled 150-cycle conversion. That makes the overlapped ordering observable: the frame lies entirely inside the busy window. With the same settings, back-to-back requests press against the settling window, and a converter held busy crosses the 250-cycle limit in a few hundred cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PULSE,
    ST_SWFRM,
    ST_WHI,
    ST_WLO,
    ST_POST,
    ST_FIN
  } seq_state_t;

  // ceiling division for converting nanoseconds into clock cycles
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (en && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/adc_seq_frame.sv
module adc_seq_frame #(
  parameter int FRAME_BITS = 16,
  parameter int SCLK_HALF  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  go,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  sdi,
  output logic                  frm_sync,
  output logic                  frm_sclk,
  output logic                  frm_sdo,
  output logic                  active,
  output logic                  fin,
  output logic [FRAME_BITS-1:0] rx_word
);

  localparam int EDGES = 2 * FRAME_BITS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam int HW    = $clog2(SCLK_HALF + 1);

  logic [HW-1:0]         div_cnt;
  logic [EW-1:0]         edge_cnt;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [FRAME_BITS-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_sync <= 1'b1;
      frm_sclk <= 1'b1;
      frm_sdo  <= 1'b0;
      active   <= 1'b0;
      fin      <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      rx_word  <= '0;
    end else begin
      fin <= 1'b0;
      if (!active) begin
        if (go) begin
          // lead half period: frame low, first bit already on the line
          active   <= 1'b1;
          frm_sync <= 1'b0;
          frm_sclk <= 1'b1;
          tx_sr    <= tx_word;
          frm_sdo  <= tx_word[FRAME_BITS-1];
          div_cnt  <= HW'(SCLK_HALF - 1);
          edge_cnt <= '0;
        end
      end else if (div_cnt != '0) begin
        div_cnt <= div_cnt - 1'b1;
      end else begin
        div_cnt <= HW'(SCLK_HALF - 1);
        if (edge_cnt == EW'(EDGES)) begin
          frm_sync <= 1'b1;
          frm_sclk <= 1'b1;
          active   <= 1'b0;
          fin      <= 1'b1;
          rx_word  <= rx_sr;
        end else if (!edge_cnt[0]) begin
          // falling edge: advance the outgoing bit (R5)
          frm_sclk <= 1'b0;
          if (edge_cnt != '0) begin
            tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
            frm_sdo <= tx_sr[FRAME_BITS-2];
          end
          edge_cnt <= edge_cnt + 1'b1;
        end else begin
          // rising edge: capture the incoming bit (R6)
          frm_sclk <= 1'b1;
          rx_sr    <= {rx_sr[FRAME_BITS-2:0], sdi};
          edge_cnt <= edge_cnt + 1'b1;
        end
      end
    end
  end

  // R4: serial clock idles high outside a frame
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    frm_sync |-> frm_sclk);

  // R4: never more than two edges per bit inside a frame
  p_edge_bound_r4: assert property (@(posedge clk) disable iff (rst)
    active |-> (edge_cnt <= EW'(EDGES)));

  // R5: outgoing data does not move on a rising edge
  p_sdo_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (active && $rose(frm_sclk)) |-> $stable(frm_sdo));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int PULSE_NS    = 100,
  parameter int ACQ_NS      = 400,
  parameter int CONV_MAX_NS = 4600,
  parameter int MARGIN_NS   = 400,
  parameter int SCLK_HALF   = 4,
  parameter int FRAME_BITS  = 16,
  parameter int RESULT_BITS = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_req,
  input  logic [FRAME_BITS-1:0]  ctrl_word,
  input  logic                   xfer_during,
  input  logic                   sw_convert,
  output logic                   ready,
  output logic                   done,
  output logic                   timeout_err,
  output logic [FRAME_BITS-1:0]  raw_word,
  output logic [RESULT_BITS-1:0] result,
  output logic                   adc_convst,
  input  logic                   adc_busy,
  output logic                   adc_sync,
  output logic                   adc_sclk,
  output logic                   adc_din,
  input  logic                   adc_dout
);

  localparam int PULSE_CYC = cdiv(PULSE_NS, CLK_NS);
  localparam int ACQ_CYC   = cdiv(ACQ_NS, CLK_NS);
  localparam int TO_CYC    = cdiv(CONV_MAX_NS + MARGIN_NS, CLK_NS);
  localparam int PW        = $clog2(PULSE_CYC + 1);
  localparam int AW        = $clog2(ACQ_CYC + 1);
  localparam int TW        = $clog2(TO_CYC + 1);

  seq_state_t state;

  logic [FRAME_BITS-1:0] ctrl_q;
  logic                  dur_q;
  logic                  sw_q;
  logic                  abort_q;
  logic                  frm_go;

  // busy resynchronisation and falling-edge detect
  logic busy_m1, busy_s, busy_d;
  logic busy_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m1 <= 1'b0;
      busy_s  <= 1'b0;
      busy_d  <= 1'b0;
    end else begin
      busy_m1 <= adc_busy;
      busy_s  <= busy_m1;
      busy_d  <= busy_s;
    end
  end

  assign busy_fall = busy_d & ~busy_s;

  // timers
  logic pulse_load, pulse_zero;
  logic gap_zero;
  logic to_load, to_en, to_zero;

  logic frm_active, frm_fin;
  logic [FRAME_BITS-1:0] frm_rx;

  assign pulse_load = (state == ST_ARM) && gap_zero && !sw_q;
  assign to_load    = ((state == ST_PULSE) && pulse_zero) ||
                      ((state == ST_SWFRM) && frm_fin);
  assign to_en      = (state == ST_WHI) || (state == ST_WLO);

  adc_seq_timer #(.W(PW)) u_pulse_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (pulse_load),
    .load_val (PW'(PULSE_CYC - 1)),
    .en       (state == ST_PULSE),
    .zero     (pulse_zero)
  );

  adc_seq_timer #(.W(AW)) u_gap_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (busy_fall),
    .load_val (AW'(ACQ_CYC)),
    .en       (1'b1),
    .zero     (gap_zero)
  );

  adc_seq_timer #(.W(TW)) u_to_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (to_load),
    .load_val (TW'(TO_CYC)),
    .en       (to_en),
    .zero     (to_zero)
  );

  adc_seq_frame #(
    .FRAME_BITS (FRAME_BITS),
    .SCLK_HALF  (SCLK_HALF)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .go       (frm_go),
    .tx_word  (ctrl_q),
    .sdi      (adc_dout),
    .frm_sync (adc_sync),
    .frm_sclk (adc_sclk),
    .frm_sdo  (adc_din),
    .active   (frm_active),
    .fin      (frm_fin),
    .rx_word  (frm_rx)
  );

  assign ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ctrl_q      <= '0;
      dur_q       <= 1'b0;
      sw_q        <= 1'b0;
      abort_q     <= 1'b0;
      frm_go      <= 1'b0;
      adc_convst  <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      raw_word    <= '0;
      result      <= '0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      frm_go      <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          // R12: requests are only taken here
          if (start_req) begin
            ctrl_q <= ctrl_word;
            dur_q  <= xfer_during;
            sw_q   <= sw_convert;
            state  <= ST_ARM;
          end
        end
        ST_ARM: begin
          // R3: hold off until the settling window has elapsed
          if (gap_zero) begin
            if (sw_q) begin
              frm_go <= 1'b1;
              state  <= ST_SWFRM;
            end else begin
              adc_convst <= 1'b1;
              state      <= ST_PULSE;
            end
          end
        end
        ST_PULSE: begin
          if (pulse_zero) begin
            adc_convst <= 1'b0;
            state      <= ST_WHI;
            if (dur_q) frm_go <= 1'b1;
          end
        end
        ST_SWFRM: begin
          if (frm_fin) state <= ST_WHI;
        end
        ST_WHI: begin
          if (to_zero) begin
            timeout_err <= 1'b1;
            abort_q     <= 1'b1;
            state       <= ST_FIN;
          end else if (busy_s) begin
            state <= ST_WLO;
          end
        end
        ST_WLO: begin
          if (to_zero) begin
            timeout_err <= 1'b1;
            abort_q     <= 1'b1;
            state       <= ST_FIN;
          end else if (!busy_s) begin
            if (dur_q || sw_q) begin
              state <= ST_FIN;
            end else begin
              frm_go <= 1'b1;
              state  <= ST_POST;
            end
          end
        end
        ST_POST: begin
          if (frm_fin) state <= ST_FIN;
        end
        ST_FIN: begin
          if (!frm_active && !frm_go) begin
            if (!abort_q) begin
              done     <= 1'b1;
              raw_word <= frm_rx;
              result   <= frm_rx[RESULT_BITS-1:0];
            end
            abort_q <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3: a strobe only rises once the settling timer has drained
  p_convst_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_convst) |-> $past(gap_zero));

  // R2: a strobe lasts beyond its first cycle when the width asks for it
  p_convst_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(adc_convst) && (PULSE_CYC > 1)) |=> adc_convst);

  // R10: completion is a single-cycle strobe
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: an aborted operation never reports completion
  p_done_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(done && timeout_err));

  // R9: software-start operations leave the strobe untouched
  p_sw_no_convst_r9: assert property (@(posedge clk) disable iff (rst)
    (sw_q && state != ST_IDLE && state != ST_ARM) |-> !adc_convst);

  // R10: results never move without the completion strobe
  p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(raw_word));

endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;

  localparam int CLK_HALF_NS = 10;
  localparam int HALF        = 2;
  localparam int PULSE_CYC   = 5;
  localparam int ACQ_CYC     = 20;
  localparam int TO_CYC      = 250;
  localparam int CONV_CYC    = 150;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_req = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        mode_dur = 1'b0;
  logic        mode_sw = 1'b0;
  logic        ready, done, timeout_err;
  logic [15:0] raw_word;
  logic [11:0] result;
  logic        adc_convst, adc_sync, adc_sclk, adc_din;
  logic        busy_m = 1'b0;
  logic        dout_m = 1'b0;

  always #(CLK_HALF_NS) clk = ~clk;

  adc_seq_ctrl #(.SCLK_HALF(HALF)) u_adc_seq_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_req   (start_req),
    .ctrl_word   (ctrl_word),
    .xfer_during (mode_dur),
    .sw_convert  (mode_sw),
    .ready       (ready),
    .done        (done),
    .timeout_err (timeout_err),
    .raw_word    (raw_word),
    .result      (result),
    .adc_convst  (adc_convst),
    .adc_busy    (busy_m),
    .adc_sync    (adc_sync),
    .adc_sclk    (adc_sclk),
    .adc_din     (adc_din),
    .adc_dout    (dout_m)
  );

  int checks = 0;
  int failures = 0;

  // monitor state
  int cyc = 0, t_fall = -1000, t_rise = -1000, hi_len = 0, conv_left = 0;
  int rises = 0, last_edge = 0, fall_seen = 0, dsel = 0;
  int frames = 0, conv_rises = 0, done_cnt = 0, err_cnt = 0, err_cyc = 0;
  logic [15:0] din_cap = '0, exp_ctrl = '0, out_word = '0;
  logic p_convst = 1'b0, p_sync = 1'b1, p_sclk = 1'b1, p_done = 1'b0;
  bit hang = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle converter model and protocol reference
  task automatic monitor_step();
    cyc++;
    if (busy_m && !hang) begin
      if (conv_left > 0) conv_left--;
      if (conv_left == 0) begin
        busy_m = 1'b0;
        t_fall = cyc;
      end
    end
    if (adc_convst && !p_convst) begin
      chk(cyc - t_fall >= ACQ_CYC, "R3 settle before strobe", cyc - t_fall, ACQ_CYC);
      chk(!mode_sw, "R9 no strobe in sw mode", 1, 0);
      conv_rises++;
      t_rise = cyc;
      hi_len = 0;
    end
    if ((adc_convst && !p_convst) || (mode_sw && adc_sync && !p_sync)) begin
      busy_m = 1'b1;
      conv_left = CONV_CYC;
    end
    if (adc_convst) hi_len++;
    if (!adc_convst && p_convst)
      chk(hi_len == PULSE_CYC, "R2 strobe width", hi_len, PULSE_CYC);
    if (!adc_sync && p_sync) begin
      rises = 0; din_cap = '0; dsel = 0; fall_seen = 0; last_edge = cyc;
      if (mode_sw)
        chk(cyc - t_fall >= ACQ_CYC, "R3 settle before sw frame", cyc - t_fall, ACQ_CYC);
      else if (mode_dur)
        chk(busy_m == 1'b1, "R7 frame inside conversion", int'(busy_m), 1);
      else
        chk(!busy_m && t_fall > t_rise, "R8 frame after busy", int'(busy_m), 0);
    end
    if (!adc_sync && !adc_sclk && p_sclk) begin
      chk(cyc - last_edge == HALF, "R4 sclk half period", cyc - last_edge, HALF);
      last_edge = cyc;
      fall_seen++;
      if (fall_seen > 1 && dsel < 15) dsel++;
    end
    if (!adc_sync && adc_sclk && !p_sclk) begin
      chk(cyc - last_edge == HALF, "R4 sclk half period", cyc - last_edge, HALF);
      last_edge = cyc;
      rises++;
      din_cap = {din_cap[14:0], adc_din};
    end
    if (adc_sync && !p_sync) begin
      frames++;
      chk(rises == 16, "R4 rising edges per frame", rises, 16);
      chk(din_cap == exp_ctrl, "R5 control word on din", int'(din_cap), int'(exp_ctrl));
    end
    if (adc_sync && !adc_sclk)
      chk(1'b0, "R4 sclk idle high", 0, 1);
    if (done) begin
      done_cnt++;
      chk(raw_word == out_word, "R6 raw word", int'(raw_word), int'(out_word));
      chk(result == out_word[11:0], "R6 result bits", int'(result), int'(out_word[11:0]));
      chk(!busy_m, "R10 done after conversion", int'(busy_m), 0);
      chk(!p_done, "R10 single-cycle done", int'(p_done), 0);
    end
    if (timeout_err) begin
      err_cnt++;
      err_cyc = cyc;
    end
    dout_m   = out_word[15 - dsel];
    p_convst = adc_convst;
    p_sync   = adc_sync;
    p_sclk   = adc_sclk;
    p_done   = done;
  endtask

  task automatic run_op(input logic [15:0] cw, input logic [15:0] ow,
                        input logic dur, input logic sw, input int limit);
    int d0 = done_cnt;
    int e0 = err_cnt;
    for (int k = 0; k < 1000 && !ready; k++) @(negedge clk);
    exp_ctrl  = cw;
    out_word  = ow;
    ctrl_word = cw;
    mode_dur  = dur;
    mode_sw   = sw;
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int k = 0; k < limit && done_cnt == d0 && err_cnt == e0; k++) @(negedge clk);
  endtask

  initial begin
    int c0, f0, d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    fork
      forever begin
        @(negedge clk);
        monitor_step();
      end
    join_none
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(adc_convst == 1'b0, "R1 convst idle", int'(adc_convst), 0);
    chk(adc_sync == 1'b1 && adc_sclk == 1'b1, "R1 serial idle", int'({adc_sync, adc_sclk}), 3);
    chk(!done && !timeout_err, "R1 strobes low", int'({done, timeout_err}), 0);
    chk(ready == 1'b1, "R1 ready", int'(ready), 1);

    // R8 post-conversion transfer
    run_op(16'hA5C3, 16'h3ABC, 1'b0, 1'b0, 2000);
    chk(done_cnt == 1 && frames == 1, "R8 after-mode completes", done_cnt, 1);

    // R7 overlapped transfer, then back to back for R3
    run_op(16'h1234, 16'hF00F, 1'b1, 1'b0, 2000);
    chk(done_cnt == 2, "R7 during-mode completes", done_cnt, 2);
    run_op(16'h00FF, 16'h8421, 1'b1, 1'b0, 2000);
    chk(done_cnt == 3, "R3 back-to-back completes", done_cnt, 3);

    // R9 software start, twice
    c0 = conv_rises;
    run_op(16'h8001, 16'h0FFF, 1'b0, 1'b1, 2000);
    run_op(16'h7E5A, 16'hC0DE, 1'b0, 1'b1, 2000);
    chk(done_cnt == 5, "R9 sw-start completes", done_cnt, 5);
    chk(conv_rises == c0, "R9 no strobe pulses", conv_rises - c0, 0);

    // R12 request while busy is ignored
    c0 = conv_rises; f0 = frames; d0 = done_cnt;
    exp_ctrl = 16'h5AA5; out_word = 16'h1357;
    ctrl_word = 16'h5AA5; mode_dur = 1'b1; mode_sw = 1'b0;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (10) @(negedge clk);
    start_req = 1'b1;
    repeat (3) @(negedge clk);
    start_req = 1'b0;
    for (int k = 0; k < 2000 && done_cnt == d0; k++) @(negedge clk);
    repeat (300) @(negedge clk);
    chk(conv_rises - c0 == 1, "R12 one strobe only", conv_rises - c0, 1);
    chk(frames - f0 == 1 && done_cnt - d0 == 1, "R12 one operation only", done_cnt - d0, 1);

    // R11 timeout on a stuck busy line
    hang = 1'b1;
    d0 = done_cnt; f0 = frames;
    run_op(16'h0F0F, 16'h2222, 1'b0, 1'b0, 2000);
    chk(err_cnt == 1, "R11 timeout flagged", err_cnt, 1);
    chk(err_cyc - t_rise >= TO_CYC && err_cyc - t_rise <= TO_CYC + PULSE_CYC + 4,
        "R11 timeout window", err_cyc - t_rise, TO_CYC + PULSE_CYC);
    @(negedge clk);
    @(negedge clk);
    chk(ready == 1'b1, "R11 back to idle", int'(ready), 1);
    chk(done_cnt == d0 && frames == f0, "R11 no done after abort", done_cnt - d0, 0);
    hang = 1'b0;
    repeat (200) @(negedge clk);

    // R11 normal operation resumes after an abort
    run_op(16'hCAFE, 16'h0ABC, 1'b1, 1'b0, 2000);
    chk(done_cnt == d0 + 1, "R11 recovers after timeout", done_cnt - d0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4_000_000);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end

endmodule